// File: doc/BRIEF.md
# Video Timing Analyzer

This block measures the timing of an incoming video stream so that firmware can set screen size and centering without manual adjustment. It watches four already-synchronised inputs: horizontal sync, vertical sync, horizontal flyback and an active-video flag. From them it derives nine 12-bit results. Six are horizontal intervals counted in measurement-clock cycles. Three are vertical distances counted in scan lines.

A run begins when the start bit is written while the select input is 1. The block then waits for a vertical sync rising edge, which is the trigger edge. It counts horizontal sync rising edges from that point to find a programmed sampling line, and on that line it takes single-shot captures of the line period and of the flyback offsets. The sync-to-video margins and video-to-sync margins, both horizontal and vertical, are tracked as minima over a programmable number of frames. The busy output mirrors the start bit and clears when the run is over. All results then hold until the next accepted start.

Top module: `video_timing_analyzer`

## Requirements
- R1: After reset, busy is 0, all nine results are 0 and all overflow flags are 0.
- R2: A start pulse while select is 0 has no effect: busy stays 0 and no result changes.
- R3: A start pulse while select is 1 and busy is 0 sets busy, preloads all nine results to 4095 and clears all overflow flags. Busy clears at the (F+1)-th vertical sync rising edge after the trigger edge, where F is the 2-bit frame field.
- R4: The sampling line starts at horizontal sync rising edge number max(4·N, 1) after the trigger edge, where N is the 8-bit block field. The line period result is the cycle count from that edge to the next horizontal sync rising edge.
- R5: Three captures are tied to the sampling line. The flyback-to-sync result is the cycle count from the latest flyback rising edge to the sampling edge. The sync-to-flyback result is the cycle count from the sampling edge to the next flyback rising edge. The flyback-width result is the length in cycles of that flyback pulse.
- R6: The sync-to-video result is the minimum, over the run window, of the cycle count from a horizontal sync rising edge to an active-video rising edge.
- R7: The video-to-sync result is the minimum, over the run window, of the cycle count from an active-video falling edge to the next horizontal sync rising edge.
- R8: Two vertical minima are kept over the F+1 frames. The first counts the horizontal sync rising edges from vertical sync to the first active-video rising edge of the frame. The second counts the horizontal sync rising edges from the last active-video falling edge to the next vertical sync rising edge.
- R9: The frame-length result is the number of horizontal sync rising edges between the trigger edge and the next vertical sync rising edge.
- R10: Interval counters saturate at 4095. A result taken from a saturated counter sets its overflow bit. The overflow bit order, LSB first, is: sync-to-video, video-to-sync, line period, flyback-to-sync, sync-to-flyback, flyback width, vertical sync-to-video, vertical video-to-sync, frame length.
- R11: A run with no active video leaves the four margin results at 4095 with their overflow bits clear.
- R12: Once busy has cleared, results stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_i | input | 1 | Horizontal sync, active high |
| vs_i | input | 1 | Vertical sync, active high |
| fly_i | input | 1 | Horizontal flyback, active high |
| act_i | input | 1 | Active-video flag |
| start_i | input | 1 | One-cycle write of the start bit |
| sel_i | input | 1 | 1 selects timing measurement |
| frames_i | input | FR_W | Frame field F; the run lasts F+1 frames |
| blk_i | input | BLK_W | Block field N; selects the sampling line |
| busy_o | output | 1 | Start bit readback; high while a run is active |
| t_hs_av_o | output | W | Minimum sync-to-video, in cycles |
| t_av_hs_o | output | W | Minimum video-to-sync, in cycles |
| t_line_o | output | W | Line period of the sampling line |
| t_fly_hs_o | output | W | Flyback rise to sampling sync edge |
| t_hs_fly_o | output | W | Sampling sync edge to flyback rise |
| t_fly_w_o | output | W | Flyback pulse width |
| n_vs_av_o | output | W | Minimum lines from vertical sync to video |
| n_av_vs_o | output | W | Minimum lines from video to vertical sync |
| n_frame_o | output | W | Lines per frame |
| ovf_o | output | 9 | Saturation flags, one per result |

## Verification
The bench widens the flyback pulse on the sampling line only. A design that miscounts the sync edges to the sampling line, or treats a zero block field as zero edges, therefore reports the wrong flyback width. A two-frame run has a shorter video start in its second frame, and a one-frame run sees that same pattern. A design that keeps the wrong number of frames reports the wrong minimum in one of the two runs. A line longer than 4095 cycles checks both saturation and the overflow bits of exactly the two affected results. A frame with no active video shows whether the margin results are left at their preload value or are wrongly updated. Starts issued with select low show whether the block ignores them and whether held results stay unchanged.

// File: rtl/vta_pkg.sv
package vta_pkg;
   localparam int NRES = 9;
   localparam int IX_HAV = 0;
   localparam int IX_AVH = 1;
   localparam int IX_LINE = 2;
   localparam int IX_FLYHS = 3;
   localparam int IX_HSFLY = 4;
   localparam int IX_FLYW = 5;
   localparam int IX_VAV = 6;
   localparam int IX_AVV = 7;
   localparam int IX_FRM = 8;
   // results kept as a running minimum; the others are single captures
   localparam logic [NRES-1:0] MIN_MASK = 9'b011000011;

   localparam int NCNT = 5;
   localparam int CX_HS = 0;
   localparam int CX_FLY = 1;
   localparam int CX_AVF = 2;
   localparam int CX_LVS = 3;
   localparam int CX_LAVF = 4;
   // counters that count scan lines rather than clock cycles
   localparam logic [NCNT-1:0] LINE_CNT = 5'b11000;

   typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} vta_state_e;
endpackage

// File: rtl/vta_edges.sv
module vta_edges #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= din[i];
      end
      assign rise[i] = din[i] & ~prev_q;
      assign fall[i] = ~din[i] & prev_q;
   end
endmodule

// File: rtl/vta_count.sv
module vta_count #(
   parameter int W        = 12,
   parameter bit START_ONE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         step,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = '1;
   localparam logic [W-1:0] RVAL = {{(W-1){1'b0}}, START_ONE};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= TOP;
      else if (restart)             cnt <= RVAL;
      else if (step && cnt != TOP)  cnt <= cnt + 1'b1;
   end

   // R10: a saturated counter stays saturated until restarted
   a_r10_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TOP && !restart) |=> cnt == TOP);
endmodule

// File: rtl/vta_seq.sv
module vta_seq
   import vta_pkg::*;
#(
   parameter int BLK_W = 8,
   parameter int FR_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             sel,
   input  logic [BLK_W-1:0] blk,
   input  logic [FR_W-1:0]  frames,
   input  logic             hs_rise,
   input  logic             vs_rise,
   output logic             accept,
   output logic             run,
   output logic             samp,
   output logic             busy
);
   localparam int TW = BLK_W + 2;

   vta_state_e       st_q;
   logic [BLK_W-1:0] blk_q;
   logic [FR_W-1:0]  left_q;
   logic [TW-1:0]    hcnt_q;
   logic             sampled_q;
   logic [TW-1:0]    tgt;
   logic [TW-1:0]    hnxt;

   assign tgt    = (blk_q == '0) ? TW'(1) : {blk_q, 2'b00};
   assign hnxt   = hcnt_q + 1'b1;
   assign accept = go && sel && (st_q == ST_IDLE);
   assign run    = (st_q == ST_RUN);
   assign busy   = (st_q != ST_IDLE);
   assign samp   = run && hs_rise && !sampled_q && (hnxt == tgt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         blk_q     <= '0;
         left_q    <= '0;
         hcnt_q    <= '0;
         sampled_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (accept) begin
               st_q   <= ST_ARM;
               blk_q  <= blk;
               left_q <= frames;
            end
            ST_ARM: if (vs_rise) begin
               st_q      <= ST_RUN;
               hcnt_q    <= '0;
               sampled_q <= 1'b0;
            end
            ST_RUN: begin
               if (hs_rise && !sampled_q) begin
                  hcnt_q <= hnxt;
                  if (hnxt == tgt) sampled_q <= 1'b1;
               end
               if (vs_rise) begin
                  if (left_q == '0) st_q <= ST_IDLE;
                  else              left_q <= left_q - 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R3: a run only ends on a vertical sync rising edge
   a_r3_ends_on_vsync: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(vs_rise));
endmodule

// File: rtl/video_timing_analyzer.sv
module video_timing_analyzer
   import vta_pkg::*;
#(
   parameter int W     = 12,
   parameter int BLK_W = 8,
   parameter int FR_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hs_i,
   input  logic             vs_i,
   input  logic             fly_i,
   input  logic             act_i,
   input  logic             start_i,
   input  logic             sel_i,
   input  logic [FR_W-1:0]  frames_i,
   input  logic [BLK_W-1:0] blk_i,
   output logic             busy_o,
   output logic [W-1:0]     t_hs_av_o,
   output logic [W-1:0]     t_av_hs_o,
   output logic [W-1:0]     t_line_o,
   output logic [W-1:0]     t_fly_hs_o,
   output logic [W-1:0]     t_hs_fly_o,
   output logic [W-1:0]     t_fly_w_o,
   output logic [W-1:0]     n_vs_av_o,
   output logic [W-1:0]     n_av_vs_o,
   output logic [W-1:0]     n_frame_o,
   output logic [NRES-1:0]  ovf_o
);
   localparam logic [W-1:0] MAXV = '1;

   if (W < 4) begin : g_bad_w
      $error("result width too small");
   end
   if (FR_W < 1 || BLK_W < 1) begin : g_bad_fields
      $error("field widths must be positive");
   end

   logic [3:0] rise, fall;
   logic h_rise, v_rise, f_rise, f_fall, a_rise, a_fall;
   vta_edges #(.N(4)) u_edges (
      .clk(clk), .rst_n(rst_n), .din({act_i, fly_i, vs_i, hs_i}),
      .rise(rise), .fall(fall));
   assign h_rise = rise[0];
   assign v_rise = rise[1];
   assign f_rise = rise[2];
   assign a_rise = rise[3];
   assign f_fall = fall[2];
   assign a_fall = fall[3];
   wire unused_edges = &{1'b0, fall[0], fall[1]};

   logic accept, run, samp;
   vta_seq #(.BLK_W(BLK_W), .FR_W(FR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(start_i), .sel(sel_i), .blk(blk_i),
      .frames(frames_i), .hs_rise(h_rise), .vs_rise(v_rise),
      .accept(accept), .run(run), .samp(samp), .busy(busy_o));

   // interval and line counters
   logic [NCNT-1:0] c_rst, c_step;
   logic [W-1:0]    cval [NCNT];
   assign c_rst  = {a_fall, v_rise, a_fall, f_rise, h_rise};
   assign c_step = {h_rise, h_rise, 1'b1, 1'b1, 1'b1};
   for (genvar c = 0; c < NCNT; c++) begin : g_cnt
      vta_count #(.W(W), .START_ONE(!LINE_CNT[c])) u_cnt (
         .clk(clk), .rst_n(rst_n), .restart(c_rst[c]), .step(c_step[c]),
         .cnt(cval[c]));
   end

   // run-window tracking flags
   logic hs_seen_q, av_done_q, av_frm_q, want_ln_q, want_hf_q, want_fw_q, v3_pend_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_seen_q <= 1'b0; av_done_q <= 1'b0; av_frm_q <= 1'b0;
         want_ln_q <= 1'b0; want_hf_q <= 1'b0; want_fw_q <= 1'b0;
         v3_pend_q <= 1'b0;
      end else if (accept) begin
         hs_seen_q <= 1'b0; av_done_q <= 1'b0; av_frm_q <= 1'b0;
         want_ln_q <= 1'b0; want_hf_q <= 1'b0; want_fw_q <= 1'b0;
         v3_pend_q <= 1'b1;
      end else begin
         if (run && h_rise) hs_seen_q <= 1'b1;
         if (run && a_fall)      av_done_q <= 1'b1;
         else if (h_rise)        av_done_q <= 1'b0;
         if (v_rise)             av_frm_q <= 1'b0;
         else if (run && a_rise) av_frm_q <= 1'b1;
         if (samp)               want_ln_q <= 1'b1;
         else if (h_rise)        want_ln_q <= 1'b0;
         if (samp)               want_hf_q <= 1'b1;
         else if (f_rise)        want_hf_q <= 1'b0;
         if (run && f_rise && want_hf_q) want_fw_q <= 1'b1;
         else if (f_fall)                want_fw_q <= 1'b0;
         if (run && v_rise)      v3_pend_q <= 1'b0;
      end
   end

   logic [W-1:0]    cand [NRES];
   logic [NRES-1:0] upd;
   always_comb begin
      cand[IX_HAV]   = cval[CX_HS];   upd[IX_HAV]   = run && a_rise && hs_seen_q;
      cand[IX_AVH]   = cval[CX_AVF];  upd[IX_AVH]   = run && h_rise && av_done_q;
      cand[IX_LINE]  = cval[CX_HS];   upd[IX_LINE]  = run && h_rise && want_ln_q;
      cand[IX_FLYHS] = cval[CX_FLY];  upd[IX_FLYHS] = samp;
      cand[IX_HSFLY] = cval[CX_HS];   upd[IX_HSFLY] = run && f_rise && want_hf_q;
      cand[IX_FLYW]  = cval[CX_FLY];  upd[IX_FLYW]  = run && f_fall && want_fw_q;
      cand[IX_VAV]   = cval[CX_LVS];  upd[IX_VAV]   = run && a_rise && !av_frm_q;
      cand[IX_AVV]   = cval[CX_LAVF]; upd[IX_AVV]   = run && v_rise && av_frm_q;
      cand[IX_FRM]   = cval[CX_LVS];  upd[IX_FRM]   = run && v_rise && v3_pend_q;
   end

   logic [W-1:0] res [NRES];
   for (genvar i = 0; i < NRES; i++) begin : g_res
      logic [W-1:0] nxt, r_q;
      logic         o_q;
      if (MIN_MASK[i]) begin : g_min
         assign nxt = (cand[i] < r_q) ? cand[i] : r_q;
      end else begin : g_cap
         assign nxt = cand[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q <= '0;
            o_q <= 1'b0;
         end else if (accept) begin
            r_q <= MAXV;
            o_q <= 1'b0;
         end else if (upd[i]) begin
            r_q <= nxt;
            if (cand[i] == MAXV) o_q <= 1'b1;
         end
      end
      assign res[i]   = r_q;
      assign ovf_o[i] = o_q;
   end

   assign t_hs_av_o  = res[IX_HAV];
   assign t_av_hs_o  = res[IX_AVH];
   assign t_line_o   = res[IX_LINE];
   assign t_fly_hs_o = res[IX_FLYHS];
   assign t_hs_fly_o = res[IX_HSFLY];
   assign t_fly_w_o  = res[IX_FLYW];
   assign n_vs_av_o  = res[IX_VAV];
   assign n_av_vs_o  = res[IX_AVV];
   assign n_frame_o  = res[IX_FRM];

   wire [NRES*W-1:0] all_res = {t_hs_av_o, t_av_hs_o, t_line_o, t_fly_hs_o, t_hs_fly_o,
                                t_fly_w_o, n_vs_av_o, n_av_vs_o, n_frame_o};

   a_r2_sel_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !sel_i && !busy_o) |=> !busy_o);
   a_r3_preload: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && sel_i && !busy_o) |=> (busy_o && t_hs_av_o == MAXV && ovf_o == '0));
   a_r6_min_falls_only: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> t_hs_av_o <= $past(t_hs_av_o));
   a_r10_line_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o[IX_LINE] |-> t_line_o == MAXV);
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(all_res));
endmodule

// File: tb/video_timing_analyzer_test.sv
module video_timing_analyzer_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hs = 1'b0, vs = 1'b0, fly = 1'b0, act = 1'b0;
   logic start = 1'b0, sel = 1'b0;
   logic [1:0] frames = '0;
   logic [7:0] blk = '0;
   logic busy;
   logic [11:0] t_hs_av, t_av_hs, t_line, t_fly_hs, t_hs_fly, t_fly_w, n_vs_av, n_av_vs, n_frame;
   logic [8:0] ovf;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   video_timing_analyzer uut (
      .clk(clk), .rst_n(rst_n), .hs_i(hs), .vs_i(vs), .fly_i(fly), .act_i(act),
      .start_i(start), .sel_i(sel), .frames_i(frames), .blk_i(blk),
      .busy_o(busy), .t_hs_av_o(t_hs_av), .t_av_hs_o(t_av_hs), .t_line_o(t_line),
      .t_fly_hs_o(t_fly_hs), .t_hs_fly_o(t_hs_fly), .t_fly_w_o(t_fly_w),
      .n_vs_av_o(n_vs_av), .n_av_vs_o(n_av_vs), .n_frame_o(n_frame), .ovf_o(ovf));

   // L, NL, AS, AE, A0, A1, FO, FW, N, F
   localparam int NV = 4;
   localparam int VEC [NV][10] = '{
      '{ 60, 20, 10, 50, 2, 17, 52, 5, 1, 0},
      '{ 80, 30, 20, 70, 5, 25, 70, 6, 2, 1},
      '{ 50, 25,  8, 44, 1, 24, 40, 3, 0, 3},
      '{100, 16, 30, 90, 3, 12, 20, 9, 3, 2}
   };

   function automatic int rd(int i);
      case (i)
         0: return int'(t_hs_av);
         1: return int'(t_av_hs);
         2: return int'(t_line);
         3: return int'(t_fly_hs);
         4: return int'(t_hs_fly);
         5: return int'(t_fly_w);
         6: return int'(n_vs_av);
         7: return int'(n_av_vs);
         default: return int'(n_frame);
      endcase
   endfunction

   function automatic string tag(int i);
      case (i)
         0: return "R6";
         1: return "R7";
         2: return "R4";
         3, 4, 5: return "R5";
         6, 7: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(string req, string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   task automatic start_run(bit s, int n, int f);
      @(negedge clk);
      sel = s; blk = 8'(n); frames = 2'(f); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // one frame; vertical sync rises 2 cycles after the line-0 sync edge
   task automatic gen_frame(int L, int NL, int AS, int AE, int A0, int A1,
                            int FO, int FW, int mark);
      for (int ln = 0; ln < NL; ln++) begin
         int fw = (ln == mark) ? FW + 2 : FW;
         for (int p = 0; p < L; p++) begin
            @(negedge clk);
            hs  = (p < 4);
            vs  = (ln == 0) && (p >= 2) && (p < 8);
            fly = (p >= FO) && (p < FO + fw);
            act = (ln >= A0) && (ln <= A1) && (p >= AS) && (p < AE);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL R3 watchdog: busy actual=%0d expected=0", busy);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int saved_line, saved_frm;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R1", "line period after reset", int'(t_line), 0);
      chk("R1", "overflow after reset", int'(ovf), 0);

      // table of patterns, one run each
      for (int v = 0; v < NV; v++) begin
         int L = VEC[v][0], NL = VEC[v][1], AS = VEC[v][2], AE = VEC[v][3];
         int A0 = VEC[v][4], A1 = VEC[v][5], FO = VEC[v][6], FW = VEC[v][7];
         int N = VEC[v][8], F = VEC[v][9];
         int mark = (N == 0) ? 1 : 4 * N;
         int e [9];
         e = '{AS, L - AE, L, L - FO, FO, FW + 2, A0, NL - A1, NL};
         start_run(1'b1, N, F);
         chk("R3", "busy after start", int'(busy), 1);
         chk("R3", "preload", int'(t_line), 4095);
         for (int f = 0; f < F + 2; f++)
            gen_frame(L, NL, AS, AE, A0, A1, FO, FW, (f == 0) ? mark : -1);
         chk("R3", "busy after window", int'(busy), 0);
         for (int i = 0; i < 9; i++) chk(tag(i), $sformatf("vec%0d res%0d", v, i), rd(i), e[i]);
         chk("R10", "no overflow", int'(ovf), 0);
      end

      // R2 / R12: start with select low, then video without any start
      saved_line = int'(t_line);
      saved_frm = int'(n_frame);
      start_run(1'b0, 1, 0);
      chk("R2", "busy with select low", int'(busy), 0);
      gen_frame(40, 10, 5, 30, 2, 7, 32, 4, 4);
      gen_frame(40, 10, 5, 30, 2, 7, 32, 4, -1);
      chk("R2", "busy after ignored start", int'(busy), 0);
      chk("R12", "line period held", int'(t_line), saved_line);
      chk("R12", "frame length held", int'(n_frame), saved_frm);

      // R6 minimum over two frames, second frame has earlier video
      start_run(1'b1, 1, 1);
      gen_frame(60, 20, 20, 50, 2, 17, 52, 5, 4);
      gen_frame(60, 20, 14, 50, 2, 17, 52, 5, -1);
      gen_frame(60, 20, 20, 50, 2, 17, 52, 5, -1);
      chk("R6", "min over two frames", int'(t_hs_av), 14);

      // R3 one-frame window must not see the second frame
      start_run(1'b1, 1, 0);
      gen_frame(60, 20, 20, 50, 2, 17, 52, 5, 4);
      gen_frame(60, 20, 14, 50, 2, 17, 52, 5, -1);
      chk("R3", "one-frame window", int'(t_hs_av), 20);

      // R11 no active video
      start_run(1'b1, 1, 0);
      gen_frame(60, 20, 10, 50, 5, 4, 52, 5, 4);
      gen_frame(60, 20, 10, 50, 5, 4, 52, 5, -1);
      chk("R11", "sync-to-video idle", int'(t_hs_av), 4095);
      chk("R11", "video-to-sync idle", int'(t_av_hs), 4095);
      chk("R11", "vsync-to-video idle", int'(n_vs_av), 4095);
      chk("R11", "video-to-vsync idle", int'(n_av_vs), 4095);
      chk("R11", "no overflow", int'(ovf), 0);
      chk("R9", "frame length idle", int'(n_frame), 20);

      // R10 saturation on a 4200-cycle line, block field 0
      start_run(1'b1, 0, 0);
      gen_frame(4200, 3, 10, 4190, 1, 1, 100, 5, 1);
      gen_frame(4200, 3, 10, 4190, 1, 1, 100, 5, -1);
      chk("R10", "line period saturated", int'(t_line), 4095);
      chk("R10", "flyback-to-sync saturated", int'(t_fly_hs), 4095);
      chk("R10", "overflow bits", int'(ovf), 9'b000001100);
      chk("R5", "sync-to-flyback long line", int'(t_hs_fly), 100);
      chk("R5", "flyback width long line", int'(t_fly_w), 7);
      chk("R7", "video-to-sync long line", int'(t_av_hs), 10);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule